// File: doc/BRIEF.md
# Acquisition Control and Status Register Block

This block is the 16-bit register front of a data-acquisition engine. A host writes two command words that configure the converter path. It fires event strobes by writing to dedicated offsets, and it reads a status word that collects the condition of the conversion path and of the result queue. The block decodes the host port. It turns each strobe write into a single-cycle pulse for the converter, the sequencer and the interrupt logic. It keeps the sticky error and progress flags, and it drives one registered interrupt line.

The command words are write-only. Their stored fields leave the block as outputs for the rest of the acquisition front end. The result queue, the channel sequencer and the interval timers live outside this block. They report to it through a data-available level, an overflow pulse, a conversion-done pulse and the sample counter's terminal-count pulse. A read of the queue offset returns the queue's head word and emits a pop pulse.

Top module: `acq_ctl`

## Requirements
- R1: While reset is asserted and after it is released, both command outputs are zero, every strobe output is low, the status word reads 0x0000 when the queue has no data, and the interrupt is low.
- R2: A write at offset 0x00 loads command word 1, keeping only bits 0 (straight-binary coding), 1 (32-bit count), 3 (scan enable), 4 (acquisition enable), 5 (DMA enable) and 7 (conversion interrupt enable). A write at offset 0x02 loads command word 2, keeping only bits 4 (second scan control), 7 (global interrupt enable), 8 and 9 (digital nibble output enables). All other bits of both words read as zero on the outputs. A new value appears on the outputs one cycle after the write.
- R3: A write at 0x08 (start convert), 0x0A (start acquisition), 0x0C (converter clear) or 0x14 (interrupt clear) raises the matching strobe output for exactly the one cycle after the write, whatever data is written. Such a write leaves both command words unchanged.
- R4: A read at 0x16 returns the queue head word in the same cycle, and the queue pop output is high for exactly the next cycle.
- R5: A read at 0x00 returns the status word. A read at any other offset returns zero. Status bit 13 follows the queue data-available input.
- R6: Status bit 9 (overflow) sets on an overflow pulse and stays set until a converter-clear strobe.
- R7: Status bit 8 (overrun) sets when a start-convert strobe arrives while the previous conversion has not completed. It stays set until a converter-clear strobe. A start convert that follows a conversion-done pulse does not set it.
- R8: Status bit 11 (acquisition in progress) sets on a start-acquisition strobe only when command 1 bit 4 is set. It clears on the sample counter's terminal count or on a converter-clear strobe.
- R9: Status bit 14 (acquisition stopped) sets when the terminal count arrives while an acquisition is in progress. It stays set until an interrupt-clear strobe.
- R10: The interrupt output is high one cycle after command 2 bit 7 is set together with either (command 1 bit 7 and queue data available) or status bit 14. With command 2 bit 7 clear, the interrupt output stays low.
- R11: A write to an offset that has no register (for example 0x04 or 0x16) changes no command word and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write enable |
| bus_rd | input | 1 | Host read enable |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data |
| fifo_data | input | 16 | Head word of the result queue |
| fifo_avail | input | 1 | Result queue holds data |
| fifo_ovf | input | 1 | Pulse: a result was lost to a full queue |
| conv_done | input | 1 | Pulse: the running conversion finished |
| sample_tc | input | 1 | Pulse: sample counter terminal count |
| cmd1_o | output | 16 | Stored command word 1 |
| cmd2_o | output | 16 | Stored command word 2 |
| conv_start_o | output | 1 | Start-convert strobe |
| acq_start_o | output | 1 | Start-acquisition strobe |
| conv_clear_o | output | 1 | Converter and queue clear strobe |
| irq_clear_o | output | 1 | Interrupt clear strobe |
| fifo_pop_o | output | 1 | Queue pop pulse after a head read |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check several relations. Each strobe pulse must trace back to a decoded access one cycle earlier. The in-progress flag may rise only from an enabled start, and it must fall after a terminal count. Overrun and overflow must hold until a clear, and the interrupt may be high only under the global enable. The bench scenarios show the rest: the exact field masks of both command words, the status bit positions, the one-cycle pulse width for different data patterns, and the fact that unmapped and strobe writes leave the command words alone. They also cover the race between a conversion-done pulse and the next start-convert strobe.

// File: rtl/acq_pkg.sv
package acq_pkg;
  // byte offsets on the host port
  localparam int OFS_CMD1 = 'h00;
  localparam int OFS_CMD2 = 'h02;
  localparam int OFS_CONV = 'h08;
  localparam int OFS_ACQ  = 'h0A;
  localparam int OFS_CLR  = 'h0C;
  localparam int OFS_ICLR = 'h14;
  localparam int OFS_FIFO = 'h16;

  // command word field masks
  localparam logic [15:0] CMD1_KEEP = 16'h00BB;
  localparam logic [15:0] CMD2_KEEP = 16'h0390;
  localparam int C1_ACQ_EN  = 4;
  localparam int C1_CIRQ_EN = 7;
  localparam int C2_GIRQ_EN = 7;

  // status bit positions
  localparam int ST_OVERRUN = 8;
  localparam int ST_OVF     = 9;
  localparam int ST_ACQ_RUN = 11;
  localparam int ST_AVAIL   = 13;
  localparam int ST_ACQ_END = 14;

  // strobe vector indices
  localparam int STB_CONV = 0;
  localparam int STB_ACQ  = 1;
  localparam int STB_CLR  = 2;
  localparam int STB_ICLR = 3;
  localparam int STB_POP  = 4;
  localparam int NUM_STB  = 5;

  typedef struct packed {
    logic acq_end;
    logic acq_run;
    logic ovf;
    logic overrun;
  } flags_t;
endpackage

// File: rtl/acq_decode.sv
module acq_decode
  import acq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int N_STB  = NUM_STB
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd1_we,
  output logic              cmd2_we,
  output logic [N_STB-1:0]  stb_hit
);
  always_comb begin
    cmd1_we            = wr && (addr == ADDR_W'(OFS_CMD1));
    cmd2_we            = wr && (addr == ADDR_W'(OFS_CMD2));
    stb_hit            = '0;
    stb_hit[STB_CONV]  = wr && (addr == ADDR_W'(OFS_CONV));
    stb_hit[STB_ACQ]   = wr && (addr == ADDR_W'(OFS_ACQ));
    stb_hit[STB_CLR]   = wr && (addr == ADDR_W'(OFS_CLR));
    stb_hit[STB_ICLR]  = wr && (addr == ADDR_W'(OFS_ICLR));
    stb_hit[STB_POP]   = rd && (addr == ADDR_W'(OFS_FIFO));
  end
endmodule

// File: rtl/acq_cmdregs.sv
module acq_cmdregs
  import acq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd1_we,
  input  logic              cmd2_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cmd1_q,
  output logic [DATA_W-1:0] cmd2_q
);
  localparam logic [DATA_W-1:0] KEEP1 = DATA_W'(CMD1_KEEP);
  localparam logic [DATA_W-1:0] KEEP2 = DATA_W'(CMD2_KEEP);

  logic [DATA_W-1:0] cmd1_d, cmd2_d;

  always_comb begin
    cmd1_d = wdata & KEEP1;
    cmd2_d = wdata & KEEP2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd1_q <= '0;
    else if (cmd1_we) cmd1_q <= cmd1_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd2_q <= '0;
    else if (cmd2_we) cmd2_q <= cmd2_d;
  end

  // R2
  undef_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd1_q & ~KEEP1) == '0) && ((cmd2_q & ~KEEP2) == '0));

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd1_we |=> $stable(cmd1_q));
endmodule

// File: rtl/acq_strobe.sv
module acq_strobe #(
  parameter int N_STB = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_STB-1:0] hit,
  output logic [N_STB-1:0] pulse
);
  for (genvar i = 0; i < N_STB; i++) begin : g_stb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[i] <= 1'b0;
      else        pulse[i] <= hit[i];
    end

    // R3
    pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |-> $past(hit[i]));
  end
endmodule

// File: rtl/acq_status.sv
module acq_status
  import acq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_pls,
  input  logic              acq_pls,
  input  logic              clr_pls,
  input  logic              iclr_pls,
  input  logic              acq_en,
  input  logic              fifo_avail,
  input  logic              fifo_ovf,
  input  logic              conv_done,
  input  logic              sample_tc,
  output flags_t            flags,
  output logic [DATA_W-1:0] status
);
  flags_t flags_d;
  logic   busy_q, busy_d;

  always_comb begin
    flags_d = flags;
    busy_d  = busy_q;
    // conversion tracking and overrun
    if (clr_pls) begin
      busy_d          = 1'b0;
      flags_d.overrun = 1'b0;
    end else begin
      if (conv_pls && busy_q && !conv_done) flags_d.overrun = 1'b1;
      if (conv_pls)       busy_d = 1'b1;
      else if (conv_done) busy_d = 1'b0;
    end
    // queue overflow
    if (clr_pls)       flags_d.ovf = 1'b0;
    else if (fifo_ovf) flags_d.ovf = 1'b1;
    // acquisition progress
    if (clr_pls || sample_tc)     flags_d.acq_run = 1'b0;
    else if (acq_pls && acq_en)   flags_d.acq_run = 1'b1;
    // acquisition end event
    if (sample_tc && flags.acq_run) flags_d.acq_end = 1'b1;
    else if (iclr_pls)              flags_d.acq_end = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      busy_q <= 1'b0;
    end else begin
      flags  <= flags_d;
      busy_q <= busy_d;
    end
  end

  always_comb begin
    status             = '0;
    status[ST_OVERRUN] = flags.overrun;
    status[ST_OVF]     = flags.ovf;
    status[ST_ACQ_RUN] = flags.acq_run;
    status[ST_AVAIL]   = fifo_avail;
    status[ST_ACQ_END] = flags.acq_end;
  end

  // R8
  acq_set_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.acq_run) |-> $past(acq_pls && acq_en));

  // R8
  acq_tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tc |=> !flags.acq_run);

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags.overrun && !clr_pls |=> flags.overrun);

  // R6
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pls |=> !flags.ovf);

  // R9
  acq_end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags.acq_end && !iclr_pls |=> flags.acq_end);
endmodule

// File: rtl/acq_irq.sv
module acq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic girq_en,
  input  logic cirq_en,
  input  logic fifo_avail,
  input  logic acq_end,
  output logic irq
);
  logic irq_d;

  always_comb irq_d = girq_en && ((cirq_en && fifo_avail) || acq_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(girq_en));
endmodule

// File: rtl/acq_ctl.sv
module acq_ctl
  import acq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_avail,
  input  logic              fifo_ovf,
  input  logic              conv_done,
  input  logic              sample_tc,
  output logic [DATA_W-1:0] cmd1_o,
  output logic [DATA_W-1:0] cmd2_o,
  output logic              conv_start_o,
  output logic              acq_start_o,
  output logic              conv_clear_o,
  output logic              irq_clear_o,
  output logic              fifo_pop_o,
  output logic              irq_o
);
  logic               cmd1_we, cmd2_we;
  logic [NUM_STB-1:0] stb_hit, stb_pls;
  logic [DATA_W-1:0]  status;
  flags_t             flags;

  acq_decode #(.ADDR_W(ADDR_W), .N_STB(NUM_STB)) u_dec (
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .cmd1_we(cmd1_we), .cmd2_we(cmd2_we), .stb_hit(stb_hit));

  acq_cmdregs #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd1_we(cmd1_we), .cmd2_we(cmd2_we),
    .wdata(bus_wdata), .cmd1_q(cmd1_o), .cmd2_q(cmd2_o));

  acq_strobe #(.N_STB(NUM_STB)) u_stb (
    .clk(clk), .rst_n(rst_n), .hit(stb_hit), .pulse(stb_pls));

  acq_status #(.DATA_W(DATA_W)) u_st (
    .clk(clk), .rst_n(rst_n),
    .conv_pls(stb_pls[STB_CONV]), .acq_pls(stb_pls[STB_ACQ]),
    .clr_pls(stb_pls[STB_CLR]), .iclr_pls(stb_pls[STB_ICLR]),
    .acq_en(cmd1_o[C1_ACQ_EN]), .fifo_avail(fifo_avail),
    .fifo_ovf(fifo_ovf), .conv_done(conv_done), .sample_tc(sample_tc),
    .flags(flags), .status(status));

  acq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .girq_en(cmd2_o[C2_GIRQ_EN]),
    .cirq_en(cmd1_o[C1_CIRQ_EN]), .fifo_avail(fifo_avail),
    .acq_end(flags.acq_end), .irq(irq_o));

  always_comb begin
    conv_start_o = stb_pls[STB_CONV];
    acq_start_o  = stb_pls[STB_ACQ];
    conv_clear_o = stb_pls[STB_CLR];
    irq_clear_o  = stb_pls[STB_ICLR];
    fifo_pop_o   = stb_pls[STB_POP];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(OFS_CMD1))      bus_rdata = status;
      else if (bus_addr == ADDR_W'(OFS_FIFO)) bus_rdata = fifo_data;
    end
  end

  // R3
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_start_o, acq_start_o, conv_clear_o, irq_clear_o}));
endmodule

// File: tb/sim_acq_ctl.sv
module sim_acq_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, fifo_data = '0;
  logic        fifo_avail = 1'b0, fifo_ovf = 1'b0, conv_done = 1'b0, sample_tc = 1'b0;
  logic [15:0] bus_rdata, cmd1_o, cmd2_o;
  logic        conv_start_o, acq_start_o, conv_clear_o, irq_clear_o, fifo_pop_o, irq_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acq_ctl u0 (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] stb_vec();
    return {conv_start_o, acq_start_o, conv_clear_o, irq_clear_o, fifo_pop_o};
  endfunction

  // write: returns at the negedge after the capturing edge
  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_status(string req, logic [15:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 5'h00;
    #1 check(req, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_in(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 cmd1", cmd1_o, 16'h0);
    check("R1 cmd2", cmd2_o, 16'h0);
    check("R1 strobes", {11'h0, stb_vec()}, 16'h0);
    check("R1 irq", {15'h0, irq_o}, 16'h0);
    rd_status("R1 status", 16'h0000);
  endtask

  task automatic t_cmd();
    wr(5'h00, 16'hFFFF); check("R2 cmd1 mask", cmd1_o, 16'h00BB);
    wr(5'h02, 16'hFFFF); check("R2 cmd2 mask", cmd2_o, 16'h0390);
    wr(5'h00, 16'h0021); check("R2 cmd1 value", cmd1_o, 16'h0021);
    wr(5'h02, 16'h0110); check("R2 cmd2 value", cmd2_o, 16'h0110);
  endtask

  task automatic t_strobes();
    logic [4:0] a[4] = '{5'h08, 5'h0A, 5'h0C, 5'h14};
    logic [4:0] e[4] = '{5'b10000, 5'b01000, 5'b00100, 5'b00010};
    for (int i = 0; i < 4; i++) begin
      wr(a[i], (i % 2 == 0) ? 16'h0000 : 16'hA5C3);
      check("R3 strobe pulse", {11'h0, stb_vec()}, {11'h0, e[i]});
      @(negedge clk);
      check("R3 strobe one cycle", {11'h0, stb_vec()}, 16'h0);
      check("R3 cmd1 kept", cmd1_o, 16'h0021);
      check("R3 cmd2 kept", cmd2_o, 16'h0110);
    end
  endtask

  task automatic t_fifo_read();
    fifo_data = 16'h3C5A;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 5'h16;
    #1 check("R4 head word", bus_rdata, 16'h3C5A);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R4 pop pulse", {15'h0, fifo_pop_o}, 16'h1);
    @(negedge clk);
    check("R4 pop one cycle", {15'h0, fifo_pop_o}, 16'h0);
    bus_rd = 1'b1; bus_addr = 5'h04;
    #1 check("R5 unmapped read", bus_rdata, 16'h0);
    bus_rd = 1'b0;
    fifo_avail = 1'b1;
    rd_status("R5 avail bit13", 16'h2000);
    fifo_avail = 1'b0;
  endtask

  task automatic t_unmapped();
    wr(5'h04, 16'hFFFF);
    check("R11 no strobe 0x04", {11'h0, stb_vec()}, 16'h0);
    wr(5'h16, 16'hFFFF);
    check("R11 no strobe 0x16", {11'h0, stb_vec()}, 16'h0);
    check("R11 cmd1 kept", cmd1_o, 16'h0021);
    check("R11 cmd2 kept", cmd2_o, 16'h0110);
  endtask

  task automatic t_overflow();
    pulse_in(fifo_ovf);
    rd_status("R6 ovf set", 16'h0200);
    repeat (3) @(negedge clk);
    rd_status("R6 ovf sticky", 16'h0200);
    wr(5'h0C, 16'h0); @(negedge clk);
    rd_status("R6 ovf cleared", 16'h0000);
  endtask

  task automatic t_overrun();
    wr(5'h08, 16'h0); @(negedge clk);
    pulse_in(conv_done);
    wr(5'h08, 16'h0); @(negedge clk);
    rd_status("R7 no overrun after done", 16'h0000);
    wr(5'h08, 16'h0); @(negedge clk);
    rd_status("R7 overrun set", 16'h0100);
    pulse_in(conv_done);
    rd_status("R7 overrun sticky", 16'h0100);
    wr(5'h0C, 16'h0); @(negedge clk);
    rd_status("R7 overrun cleared", 16'h0000);
  endtask

  task automatic t_acq();
    wr(5'h00, 16'h0000);
    wr(5'h0A, 16'h0); @(negedge clk);
    rd_status("R8 start ignored without enable", 16'h0000);
    wr(5'h00, 16'h0010);
    wr(5'h0A, 16'h0); @(negedge clk);
    rd_status("R8 running", 16'h0800);
    wr(5'h0C, 16'h0); @(negedge clk);
    rd_status("R8 clear stops", 16'h0000);
    pulse_in(sample_tc);
    rd_status("R9 no end when idle", 16'h0000);
    wr(5'h0A, 16'h0); @(negedge clk);
    pulse_in(sample_tc);
    rd_status("R8 R9 tc ends run", 16'h4000);
    wr(5'h14, 16'h0); @(negedge clk);
    rd_status("R9 end cleared", 16'h0000);
  endtask

  task automatic t_irq();
    wr(5'h00, 16'h0080);
    wr(5'h02, 16'h0000);
    fifo_avail = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 no irq without global enable", {15'h0, irq_o}, 16'h0);
    wr(5'h02, 16'h0080); @(negedge clk);
    check("R10 conversion irq", {15'h0, irq_o}, 16'h1);
    fifo_avail = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 irq drops", {15'h0, irq_o}, 16'h0);
    wr(5'h00, 16'h0010);
    wr(5'h0A, 16'h0); @(negedge clk);
    pulse_in(sample_tc);
    @(negedge clk);
    check("R10 end irq", {15'h0, irq_o}, 16'h1);
    wr(5'h14, 16'h0); repeat (2) @(negedge clk);
    check("R10 end irq cleared", {15'h0, irq_o}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd();
    t_strobes();
    t_fifo_read();
    t_unmapped();
    t_overflow();
    t_overrun();
    t_acq();
    t_irq();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule